// File: doc/BRIEF.md
# Class-Directed Dispatch Router

This block sits between the rename stage and the issue queues of an out-of-order core. Each cycle it may accept a group of up to four renamed micro-ops in program order. Each micro-op carries an execution class. The router holds the group in a routing stage. There it picks one of eight physical issue queues for every micro-op and checks that every picked queue has both a write port and a free entry for it. If all of them fit, the whole group is written on the following cycle through per-queue write ports. If any one fails, nothing is written, the group stays held and the input is back-pressured until room appears or a flush removes the group.

Where a class has a primary and a secondary queue, the router always tries the primary first. It spills to the secondary only when the primary has no port or no entry left for that slot, and it never balances by load. Slots are placed oldest first, so older slots win contended ports. Within a queue, write port 0 always carries the older of two writes. Block-boundary micro-ops are consumed without taking any queue. Block-argument sources are stripped from the written entry. Per-source ready bits, supplied on an input in place of a ready-table lookup, pass through, except that absent sources are written as ready. All other per-micro-op metadata is passed through untouched.

Queue ids are: 0 ALU primary, 1 shared (ALU secondary, FSU, SYS), 2 branch, 3 AGU primary, 4 AGU secondary, 5 store-data primary, 6 store-data secondary, 7 command.

Top module: `dispatch_router`

## Requirements
- R1: Class codes are: ALU=0, BRU=1, AGU=2, STD=3, FSU=4, SYS=5, CMD=6 and BND=7. With room available, they map to queues as follows: ALU→0, BRU→2, AGU→3, STD→5, FSU→1, SYS→1, CMD→7.
- R2: A micro-op spills to its secondary queue (ALU→1, AGU→4, STD→6) only when its primary queue has no port left or no free entry left after older slots. BRU, FSU, SYS and CMD never spill.
- R3: A queue receives at most two writes in a cycle. It never receives more writes than the free count it reported in the routing cycle.
- R4: Slots are placed in order, from slot 0 (oldest) upward. When a queue takes two writes, port 0 carries the older slot and port 1 the younger. Port 1 is never used without port 0.
- R5: If any valid micro-op of the held group cannot be placed, no write occurs and `grp_ready` is low. The group stays held. It dispatches once the free counts let every micro-op fit.
- R6: A micro-op of class BND (7) is never written to any queue and uses no port or entry.
- R7: A source of kind 4 (block argument) is written as kind 0 (none) with ready 1. A source of kind 0 is written with ready 1. Kinds 1 to 3 are written with their input ready bit.
- R8: The `META_W`-bit metadata of each micro-op reaches its queue entry unchanged.
- R9: A group loaded at clock edge k, if it fits, appears on the write ports after edge k+1, for exactly one cycle.
- R10: `flush` discards the held group and any write registered at the same edge. `grp_ready` is high in the next cycle.
- R11: After reset no write port is enabled and `grp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Kill held group and pending writes |
| in_valid | input | SLOTS | Per-slot valid of offered group |
| in_cls | input | SLOTS*3 | Per-slot class code |
| in_meta | input | SLOTS*META_W | Per-slot pass-through metadata |
| in_src_kind | input | SLOTS*9 | Per-slot, per-source operand kind (3 bits each) |
| in_src_ready | input | SLOTS*3 | Per-slot, per-source ready bit from lookup |
| q_free | input | 8*FREE_W | Free entry count per queue |
| grp_ready | output | 1 | Group is accepted this cycle |
| wr_en | output | 8*PORTS | Write enable per queue port (index q*PORTS+p) |
| wr_meta | output | 8*PORTS*META_W | Metadata per queue port |
| wr_src_kind | output | 8*PORTS*9 | Filtered source kinds per queue port |
| wr_src_ready | output | 8*PORTS*3 | Initial source ready bits per queue port |

## Verification
Port exhaustion and entry exhaustion can both trigger in the same cycle. A primary queue can run out of ports for one slot while another queue lacks entries for a younger slot, so spill and whole-group stall decide together. A sweep over every four-slot class combination provokes this under three free-count profiles: ample room, a mixed 0/1/2 pattern and one entry everywhere. For each group the bench predicts the placement or stall and compares grant status and every port's enable and payload. A held-group test also lets a flush meet a stalled group, and a queue freeing up while a group is held, and checks that only the complete group is ever written.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int CLS_W = 3;
  localparam int SK_W  = 3;
  localparam int SRCS  = 3;
  localparam int NUM_Q = 8;
  localparam int QID_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU = 3'd0, CL_BRU = 3'd1, CL_AGU = 3'd2, CL_STD = 3'd3,
    CL_FSU = 3'd4, CL_SYS = 3'd5, CL_CMD = 3'd6, CL_BND = 3'd7
  } uop_class_e;

  typedef enum logic [SK_W-1:0] {
    SK_NONE = 3'd0, SK_P = 3'd1, SK_T = 3'd2, SK_U = 3'd3, SK_BARG = 3'd4
  } src_kind_e;

  localparam logic [QID_W-1:0] Q_ALU0 = 3'd0;
  localparam logic [QID_W-1:0] Q_SHRD = 3'd1;
  localparam logic [QID_W-1:0] Q_BRU  = 3'd2;
  localparam logic [QID_W-1:0] Q_AGU0 = 3'd3;
  localparam logic [QID_W-1:0] Q_AGU1 = 3'd4;
  localparam logic [QID_W-1:0] Q_STD0 = 3'd5;
  localparam logic [QID_W-1:0] Q_STD1 = 3'd6;
  localparam logic [QID_W-1:0] Q_CMD  = 3'd7;
endpackage

// File: rtl/dr_class_map.sv
module dr_class_map
  import dr_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic [CLS_W-1:0] cls     [SLOTS],
  output logic [QID_W-1:0] prim_q  [SLOTS],
  output logic [QID_W-1:0] sec_q   [SLOTS],
  output logic             has_sec [SLOTS],
  output logic             is_bnd  [SLOTS]
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_comb begin
      prim_q[s]  = Q_CMD;
      sec_q[s]   = Q_CMD;
      has_sec[s] = 1'b0;
      is_bnd[s]  = 1'b0;
      case (uop_class_e'(cls[s]))
        CL_ALU: begin prim_q[s] = Q_ALU0; sec_q[s] = Q_SHRD; has_sec[s] = 1'b1; end
        CL_AGU: begin prim_q[s] = Q_AGU0; sec_q[s] = Q_AGU1; has_sec[s] = 1'b1; end
        CL_STD: begin prim_q[s] = Q_STD0; sec_q[s] = Q_STD1; has_sec[s] = 1'b1; end
        CL_BRU: prim_q[s] = Q_BRU;
        CL_FSU: prim_q[s] = Q_SHRD;
        CL_SYS: prim_q[s] = Q_SHRD;
        CL_CMD: prim_q[s] = Q_CMD;
        default: is_bnd[s] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dr_port_alloc.sv
module dr_port_alloc
  import dr_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int PORTS  = 2,
  parameter int FREE_W = 3,
  localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              valid    [SLOTS],
  input  logic              is_bnd   [SLOTS],
  input  logic [QID_W-1:0]  prim_q   [SLOTS],
  input  logic [QID_W-1:0]  sec_q    [SLOTS],
  input  logic              has_sec  [SLOTS],
  input  logic [FREE_W-1:0] free_q   [NUM_Q],
  output logic [QID_W-1:0]  grant_q  [SLOTS],
  output logic [PW-1:0]     grant_p  [SLOTS],
  output logic              placed   [SLOTS],
  output logic              fits
);
  int used [NUM_Q];

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) used[q] = 0;
    fits = 1'b1;
    for (int s = 0; s < SLOTS; s++) begin
      placed[s]  = 1'b0;
      grant_q[s] = prim_q[s];
      grant_p[s] = '0;
      if (valid[s] && !is_bnd[s]) begin
        if (used[prim_q[s]] < PORTS && used[prim_q[s]] < int'(free_q[prim_q[s]])) begin
          placed[s]  = 1'b1;
          grant_p[s] = PW'(used[prim_q[s]]);
          used[prim_q[s]] = used[prim_q[s]] + 1;
        end else if (has_sec[s] && used[sec_q[s]] < PORTS &&
                     used[sec_q[s]] < int'(free_q[sec_q[s]])) begin
          placed[s]  = 1'b1;
          grant_q[s] = sec_q[s];
          grant_p[s] = PW'(used[sec_q[s]]);
          used[sec_q[s]] = used[sec_q[s]] + 1;
        end else begin
          fits = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dr_src_filter.sv
module dr_src_filter
  import dr_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic [SK_W-1:0] kind_in  [SLOTS][SRCS],
  input  logic            rdy_in   [SLOTS][SRCS],
  output logic [SK_W-1:0] kind_out [SLOTS][SRCS],
  output logic            rdy_out  [SLOTS][SRCS]
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar j = 0; j < SRCS; j++) begin : g_src
      always_comb begin
        if (kind_in[s][j] == SK_BARG || kind_in[s][j] == SK_NONE) begin
          kind_out[s][j] = SK_NONE;
          rdy_out[s][j]  = 1'b1;
        end else begin
          kind_out[s][j] = kind_in[s][j];
          rdy_out[s][j]  = rdy_in[s][j];
        end
      end
    end
  end
endmodule

// File: rtl/dispatch_router.sv
module dispatch_router
  import dr_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int PORTS  = 2,
  parameter int FREE_W = 3,
  parameter int META_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [SLOTS-1:0]                 in_valid,
  input  logic [SLOTS*CLS_W-1:0]           in_cls,
  input  logic [SLOTS*META_W-1:0]          in_meta,
  input  logic [SLOTS*SRCS*SK_W-1:0]       in_src_kind,
  input  logic [SLOTS*SRCS-1:0]            in_src_ready,
  input  logic [NUM_Q*FREE_W-1:0]          q_free,
  output logic                             grp_ready,
  output logic [NUM_Q*PORTS-1:0]           wr_en,
  output logic [NUM_Q*PORTS*META_W-1:0]    wr_meta,
  output logic [NUM_Q*PORTS*SRCS*SK_W-1:0] wr_src_kind,
  output logic [NUM_Q*PORTS*SRCS-1:0]      wr_src_ready
);
  localparam int WS = NUM_Q * PORTS;
  localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1;

  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  // input unpacking
  logic [CLS_W-1:0]  cls_in  [SLOTS];
  logic [META_W-1:0] meta_in [SLOTS];
  logic [SK_W-1:0]   kind_in [SLOTS][SRCS];
  logic              rdy_in  [SLOTS][SRCS];
  logic [FREE_W-1:0] free_q  [NUM_Q];

  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    assign cls_in[s]  = in_cls[s*CLS_W +: CLS_W];
    assign meta_in[s] = in_meta[s*META_W +: META_W];
    for (genvar j = 0; j < SRCS; j++) begin : g_src
      assign kind_in[s][j] = in_src_kind[(s*SRCS+j)*SK_W +: SK_W];
      assign rdy_in[s][j]  = in_src_ready[s*SRCS+j];
    end
  end
  for (genvar q = 0; q < NUM_Q; q++) begin : g_free
    assign free_q[q] = q_free[q*FREE_W +: FREE_W];
  end

  // routing-stage registers
  logic              s1_valid, s1_valid_nxt, s1_load;
  logic              s1_vm   [SLOTS];
  logic [CLS_W-1:0]  s1_cls  [SLOTS];
  logic [META_W-1:0] s1_meta [SLOTS];
  logic [SK_W-1:0]   s1_kind [SLOTS][SRCS];
  logic              s1_rdy  [SLOTS][SRCS];

  // routing-stage logic
  logic              route_vm [SLOTS];
  logic [QID_W-1:0]  prim_q   [SLOTS];
  logic [QID_W-1:0]  sec_q    [SLOTS];
  logic              has_sec  [SLOTS];
  logic              is_bnd   [SLOTS];
  logic [QID_W-1:0]  grant_q  [SLOTS];
  logic [PW-1:0]     grant_p  [SLOTS];
  logic              placed   [SLOTS];
  logic              fits, go;
  logic [SK_W-1:0]   f_kind   [SLOTS][SRCS];
  logic              f_rdy    [SLOTS][SRCS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_vm
    assign route_vm[s] = s1_vm[s] & s1_valid;
  end

  dr_class_map #(.SLOTS(SLOTS)) u_map (
    .cls(s1_cls), .prim_q(prim_q), .sec_q(sec_q), .has_sec(has_sec), .is_bnd(is_bnd)
  );

  dr_port_alloc #(.SLOTS(SLOTS), .PORTS(PORTS), .FREE_W(FREE_W)) u_alloc (
    .valid(route_vm), .is_bnd(is_bnd), .prim_q(prim_q), .sec_q(sec_q),
    .has_sec(has_sec), .free_q(free_q), .grant_q(grant_q), .grant_p(grant_p),
    .placed(placed), .fits(fits)
  );

  dr_src_filter #(.SLOTS(SLOTS)) u_filt (
    .kind_in(s1_kind), .rdy_in(s1_rdy), .kind_out(f_kind), .rdy_out(f_rdy)
  );

  assign grp_ready = !s1_valid || fits;

  always_comb begin
    s1_load = grp_ready && !flush;
    go      = s1_valid && fits && !flush;
    if (flush)          s1_valid_nxt = 1'b0;
    else if (grp_ready) s1_valid_nxt = |in_valid;
    else                s1_valid_nxt = s1_valid;
  end

  always_ff @(posedge clk or negedge rst_q2) begin
    if (!rst_q2) s1_valid <= 1'b0;
    else         s1_valid <= s1_valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      for (int s = 0; s < SLOTS; s++) begin
        s1_vm[s]   <= in_valid[s];
        s1_cls[s]  <= cls_in[s];
        s1_meta[s] <= meta_in[s];
        for (int j = 0; j < SRCS; j++) begin
          s1_kind[s][j] <= kind_in[s][j];
          s1_rdy[s][j]  <= rdy_in[s][j];
        end
      end
    end
  end

  // write-port steering, slot order preserved by port index
  logic              w_en_nxt   [WS];
  logic [META_W-1:0] w_meta_nxt [WS];
  logic [SK_W-1:0]   w_kind_nxt [WS][SRCS];
  logic              w_rdy_nxt  [WS][SRCS];

  always_comb begin
    for (int w = 0; w < WS; w++) begin
      w_en_nxt[w]   = 1'b0;
      w_meta_nxt[w] = '0;
      for (int j = 0; j < SRCS; j++) begin
        w_kind_nxt[w][j] = SK_NONE;
        w_rdy_nxt[w][j]  = 1'b0;
      end
      for (int s = 0; s < SLOTS; s++) begin
        if (go && placed[s] && grant_q[s] == QID_W'(w / PORTS) &&
            grant_p[s] == PW'(w % PORTS)) begin
          w_en_nxt[w]   = 1'b1;
          w_meta_nxt[w] = s1_meta[s];
          for (int j = 0; j < SRCS; j++) begin
            w_kind_nxt[w][j] = f_kind[s][j];
            w_rdy_nxt[w][j]  = f_rdy[s][j];
          end
        end
      end
    end
  end

  // write-stage registers
  logic              w_en   [WS];
  logic [META_W-1:0] w_meta [WS];
  logic [SK_W-1:0]   w_kind [WS][SRCS];
  logic              w_rdy  [WS][SRCS];

  always_ff @(posedge clk or negedge rst_q2) begin
    if (!rst_q2) begin
      for (int w = 0; w < WS; w++) w_en[w] <= 1'b0;
    end else begin
      for (int w = 0; w < WS; w++) w_en[w] <= w_en_nxt[w];
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      for (int w = 0; w < WS; w++) begin
        w_meta[w] <= w_meta_nxt[w];
        for (int j = 0; j < SRCS; j++) begin
          w_kind[w][j] <= w_kind_nxt[w][j];
          w_rdy[w][j]  <= w_rdy_nxt[w][j];
        end
      end
    end
  end

  for (genvar w = 0; w < WS; w++) begin : g_out
    assign wr_en[w] = w_en[w];
    assign wr_meta[w*META_W +: META_W] = w_meta[w];
    for (genvar j = 0; j < SRCS; j++) begin : g_src
      assign wr_src_kind[(w*SRCS+j)*SK_W +: SK_W] = w_kind[w][j];
      assign wr_src_ready[w*SRCS+j] = w_rdy[w][j];
    end
  end
endmodule

// File: rtl/dispatch_router_checker.sv
module dispatch_router_checker
  import dr_pkg::*;
#(
  parameter int PORTS  = 2,
  parameter int FREE_W = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             flush,
  input logic                             grp_ready,
  input logic [NUM_Q*FREE_W-1:0]          q_free,
  input logic [NUM_Q*PORTS-1:0]           wr_en,
  input logic [NUM_Q*PORTS*SRCS*SK_W-1:0] wr_src_kind
);
  // R5: a stalled group produces no write at the next edge
  a_r5_atomic_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_ready |=> (wr_en == '0));

  // R10: flush kills the pending write and frees the routing stage
  a_r10_flush_kill: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_en == '0 && grp_ready));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    // R3: writes per queue bounded by the free count seen in the routing cycle
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en[q*PORTS +: PORTS]) |->
        ($countones(wr_en[q*PORTS +: PORTS]) <= int'($past(q_free[q*FREE_W +: FREE_W]))));
    for (genvar p = 1; p < PORTS; p++) begin : g_p
      // R4: younger port used only behind the older one
      a_r4_port_packing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[q*PORTS+p] |-> wr_en[q*PORTS+p-1]);
    end
    for (genvar p = 0; p < PORTS; p++) begin : g_pk
      for (genvar j = 0; j < SRCS; j++) begin : g_s
        // R7: block-argument sources never reach a queue
        a_r7_no_barg: assert property (@(posedge clk) disable iff (!rst_n)
          wr_en[q*PORTS+p] |->
            (wr_src_kind[((q*PORTS+p)*SRCS+j)*SK_W +: SK_W] != SK_BARG));
      end
    end
  end
endmodule

bind dispatch_router dispatch_router_checker #(.PORTS(PORTS), .FREE_W(FREE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .grp_ready(grp_ready),
  .q_free(q_free), .wr_en(wr_en), .wr_src_kind(wr_src_kind)
);

// File: tb/dispatch_router_bench.sv
module dispatch_router_bench;
  localparam int SL = 4;
  localparam int NQ = 8;
  localparam int MW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic flush;
  logic [SL-1:0]      in_valid;
  logic [SL*3-1:0]    in_cls;
  logic [SL*MW-1:0]   in_meta;
  logic [SL*9-1:0]    in_src_kind;
  logic [SL*3-1:0]    in_src_ready;
  logic [NQ*3-1:0]    q_free;
  logic               grp_ready;
  logic [NQ*2-1:0]    wr_en;
  logic [NQ*2*MW-1:0] wr_meta;
  logic [NQ*2*9-1:0]  wr_src_kind;
  logic [NQ*2*3-1:0]  wr_src_ready;

  always #10 clk = ~clk;

  dispatch_router #(.SLOTS(SL), .PORTS(2), .FREE_W(3), .META_W(MW)) u_dispatch_router (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_cls(in_cls),
    .in_meta(in_meta), .in_src_kind(in_src_kind), .in_src_ready(in_src_ready),
    .q_free(q_free), .grp_ready(grp_ready), .wr_en(wr_en), .wr_meta(wr_meta),
    .wr_src_kind(wr_src_kind), .wr_src_ready(wr_src_ready)
  );

  int checks = 0;
  int failures = 0;
  int free_v [NQ];
  int exp_slot [NQ][2];
  bit exp_fits;
  logic [MW-1:0] slot_meta [SL];
  logic [8:0]    slot_kind [SL];
  logic [2:0]    slot_rdy  [SL];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int prim_of(input int c);
    case (c)
      0: return 0; 1: return 2; 2: return 3; 3: return 5;
      4: return 1; 5: return 1; 6: return 7; default: return -1;
    endcase
  endfunction

  function automatic int sec_of(input int c);
    case (c)
      0: return 1; 2: return 4; 3: return 6; default: return -1;
    endcase
  endfunction

  task automatic model(input logic [11:0] cls, input logic [3:0] vm);
    int used [NQ];
    for (int q = 0; q < NQ; q++) begin
      used[q] = 0; exp_slot[q][0] = -1; exp_slot[q][1] = -1;
    end
    exp_fits = 1'b1;
    for (int s = 0; s < SL; s++) begin
      int c = int'(cls[s*3 +: 3]);
      int p = prim_of(c);
      int d = sec_of(c);
      if (vm[s] && p >= 0) begin
        if (used[p] < 2 && used[p] < free_v[p]) begin
          exp_slot[p][used[p]] = s; used[p]++;
        end else if (d >= 0 && used[d] < 2 && used[d] < free_v[d]) begin
          exp_slot[d][used[d]] = s; used[d]++;
        end else exp_fits = 1'b0;
      end
    end
  endtask

  task automatic drive(input logic [11:0] cls, input logic [3:0] vm, input int tag);
    for (int q = 0; q < NQ; q++) q_free[q*3 +: 3] = 3'(free_v[q]);
    in_valid = vm;
    in_cls = cls;
    for (int s = 0; s < SL; s++) begin
      slot_meta[s] = MW'((tag << 2) ^ s ^ 16'h5A00);
      for (int j = 0; j < 3; j++) begin
        slot_kind[s][j*3 +: 3] = 3'((tag + s + j) % 5);
        slot_rdy[s][j] = 1'((tag >> (s*3 + j)) & 1);
      end
      in_meta[s*MW +: MW] = slot_meta[s];
      in_src_kind[s*9 +: 9] = slot_kind[s];
      in_src_ready[s*3 +: 3] = slot_rdy[s];
    end
  endtask

  task automatic compare_writes(input string req);
    for (int q = 0; q < NQ; q++) begin
      logic [1:0] ee;
      ee = {exp_slot[q][1] >= 0, exp_slot[q][0] >= 0};
      chk(wr_en[q*2 +: 2] == ee, req, $sformatf("wr_en q%0d", q), wr_en[q*2 +: 2], ee);
      for (int p = 0; p < 2; p++) begin
        if (ee[p]) begin
          int s = exp_slot[q][p];
          int w = q*2 + p;
          logic [8:0] ek;
          logic [2:0] er;
          for (int j = 0; j < 3; j++) begin
            logic [2:0] k;
            k = slot_kind[s][j*3 +: 3];
            ek[j*3 +: 3] = (k == 3'd4) ? 3'd0 : k;
            er[j] = (k == 3'd0 || k == 3'd4) ? 1'b1 : slot_rdy[s][j];
          end
          chk(wr_meta[w*MW +: MW] == slot_meta[s], "R4/R8", $sformatf("meta q%0d p%0d", q, p),
              wr_meta[w*MW +: MW], slot_meta[s]);
          chk(wr_src_kind[w*9 +: 9] == ek && wr_src_ready[w*3 +: 3] == er, "R7",
              $sformatf("src q%0d p%0d", q, p),
              {wr_src_kind[w*9 +: 9], wr_src_ready[w*3 +: 3]}, {ek, er});
        end
      end
    end
  endtask

  task automatic run_group(input logic [11:0] cls, input logic [3:0] vm, input int tag,
                           input string req);
    model(cls, vm);
    drive(cls, vm, tag);
    @(negedge clk);
    in_valid = '0;
    chk(grp_ready == exp_fits, "R5", "grp_ready after load", grp_ready, exp_fits);
    @(negedge clk);
    if (exp_fits) begin
      compare_writes(req);
      @(negedge clk);
      chk(wr_en == '0, "R9", "write lasts one cycle", wr_en, 0);
    end else begin
      chk(wr_en == '0, "R5", "no partial write", wr_en, 0);
      chk(grp_ready == 1'b0, "R5", "group held", grp_ready, 0);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      chk(grp_ready == 1'b1 && wr_en == '0, "R10", "flush clears held group",
          {grp_ready, wr_en}, {1'b1, 16'h0});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flush = 1'b0;
    in_valid = '0; in_cls = '0; in_meta = '0; in_src_kind = '0; in_src_ready = '0;
    for (int q = 0; q < NQ; q++) free_v[q] = 7;
    q_free = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_en == '0, "R11", "wr_en after reset", wr_en, 0);
    chk(grp_ready == 1'b1, "R11", "grp_ready after reset", grp_ready, 1);

    // R6: all-boundary group consumes nothing
    run_group(12'hFFF, 4'hF, 1, "R6");
    chk(wr_en == '0, "R6", "boundary group idle", wr_en, 0);

    // R5: held group released when the primary queue frees an entry
    for (int q = 0; q < NQ; q++) free_v[q] = 7;
    free_v[0] = 0; free_v[1] = 2;
    model({3'd1, 3'd0, 3'd0, 3'd0}, 4'hF);
    drive({3'd1, 3'd0, 3'd0, 3'd0}, 4'hF, 77);
    @(negedge clk);
    in_valid = '0;
    chk(grp_ready == 1'b0, "R5", "stall on full spill queue", grp_ready, 0);
    @(negedge clk);
    chk(wr_en == '0, "R5", "nothing written while held", wr_en, 0);
    free_v[0] = 1;
    q_free[2:0] = 3'd1;
    #1;
    chk(grp_ready == 1'b1, "R5", "group fits after free rises", grp_ready, 1);
    model({3'd1, 3'd0, 3'd0, 3'd0}, 4'hF);
    @(negedge clk);
    chk(wr_en == 16'h001D, "R2", "released placement", wr_en, 16'h001D);
    compare_writes("R2");

    // R10: flush during the routing cycle of a fitting group
    for (int q = 0; q < NQ; q++) free_v[q] = 7;
    drive({3'd0, 3'd0, 3'd1, 3'd6}, 4'h3, 5);
    @(negedge clk);
    in_valid = '0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(wr_en == '0 && grp_ready, "R10", "flush kills routed group",
        {grp_ready, wr_en}, {1'b1, 16'h0});

    // sweeps over every class combination under three free profiles
    for (int pat = 0; pat < 3; pat++) begin
      for (int g = 0; g < 4096; g++) begin
        logic [3:0] vm;
        for (int q = 0; q < NQ; q++)
          free_v[q] = (pat == 0) ? 7 : (pat == 1) ? (q % 3) : 1;
        vm = (pat == 2) ? 4'((g * 5 + 3) ^ (g >> 4)) : 4'hF;
        run_group(12'(g), vm, g + pat * 4096,
                  (pat == 0) ? "R1" : (pat == 1) ? "R2" : "R3");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule